// File: doc/BRIEF.md
# Cell Input Framer with Short/Long Cell Handling

This block sits at the write side of a cell buffer. It accepts a beat stream qualified by an active-low write strobe and marked by a start-of-cell flag, and it emits fixed-length cells one beat at a time to the buffer. A cell opens only on a written beat that carries the start-of-cell flag while the downstream side reports room for a whole cell. From then on every written beat belongs to that cell until a beat counter reaches the cell length. The last beat of the cell is marked, and the framer goes back to hunting for the next start-of-cell.

Malformed framing is absorbed without resynchronising. A start-of-cell flag that arrives before the cell is full is treated as plain data. The cell that is open keeps filling with the head of the next incoming cell, and the tail of that next cell is thrown away because it carries no start flag. The cell that comes after it frames cleanly again. Any cell that swallowed such a flag is reported bad on its last beat. Beats that run past the cell length with no new start flag are discarded, and each discarded beat shows up on a drop strobe. All outputs are registered one cycle behind the input beat.

Top module: `cif_framer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, o_valid, o_first, o_last, o_bad and o_drop are all low.
- R2: When no cell is open, a beat with wr_n low, sof high and room high opens a cell. A beat with wr_n low that does not meet all three conditions is discarded: o_drop is high for one cycle in the next cycle.
- R3: Each beat of an open cell appears on o_data with o_valid high in the cycle after it is written, in input order. o_first is high only on the beat that opened the cell.
- R4: Every cell holds exactly CELL_BYTES/BEAT_BYTES beats, which is 53 by default. o_last is high on the final beat, and no further beat joins that cell.
- R5: A sof flag on a written beat inside an open cell does not restart the cell. That beat is forwarded as ordinary data and the count keeps running.
- R6: After a cell closes, written beats without sof are dropped with o_drop. This covers the excess of a long cell and the tail of a cell whose head filled a short cell.
- R7: o_bad is high together with o_last when the cell received a mid-cell sof, and low otherwise. The next correctly framed cell after the discarded tail reports o_bad low.
- R8: A cycle with wr_n high has no effect. The next cycle shows neither o_valid nor o_drop, and the beat count does not advance.
- R9: o_valid and o_drop are never high together. o_first and o_last are only high with o_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_n | input | 1 | Beat write strobe, active low |
| sof | input | 1 | Start-of-cell flag for the current beat |
| room | input | 1 | Downstream can take a whole cell; sampled only when a cell opens |
| din | input | 8*BEAT_BYTES | Beat data |
| o_valid | output | 1 | Forwarded beat valid |
| o_data | output | 8*BEAT_BYTES | Forwarded beat data |
| o_first | output | 1 | First beat of a cell |
| o_last | output | 1 | Last beat of a cell (cell-complete pulse) |
| o_bad | output | 1 | Completed cell contains a short-cell event |
| o_drop | output | 1 | A written beat was discarded |

## Verification
The bench covers four framing faults:
- A start flag in mid-cell. A design that resynchronised on it would emit a short cell or an early o_first.
- A cell that runs five beats long. A design with a wrong counter bound would forward the extra beats or close the cell early.
- The tail of the cell that filled a short cell. A design that did not drop it would open a spurious cell, and one that lost the error mark would leave the corrupted cell unflagged.
- A start flag offered with room low, and write bubbles with sof set inside cells. A design that gated its inputs wrongly would open a cell or step the count on those cycles.

// File: rtl/cif_pkg.sv
package cif_pkg;

   typedef enum logic {
      CIF_HUNT = 1'b0,
      CIF_FILL = 1'b1
   } cif_state_e;

   function automatic int cif_cnt_width(input int beats);
      return $clog2(beats + 1);
   endfunction

endpackage

// File: rtl/cif_beat_counter.sv
module cif_beat_counter #(
   parameter int CELL_BEATS = 53,
   localparam int CNT_W = cif_pkg::cif_cnt_width(CELL_BEATS)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic step,
   output logic at_end
);

   logic [CNT_W-1:0] cnt_q;

   assign at_end = (cnt_q == CNT_W'(CELL_BEATS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= CNT_W'(1);
      end else if (step) begin
         cnt_q <= at_end ? '0 : cnt_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/cif_fault_track.sv
module cif_fault_track #(
   parameter bit ERR_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic mark,
   input  logic close,
   output logic bad_now
);

   generate
      if (ERR_EN) begin : g_track
         logic flag_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flag_q <= 1'b0;
            end else if (clear || close) begin
               flag_q <= 1'b0;
            end else if (mark) begin
               flag_q <= 1'b1;
            end
         end
         assign bad_now = close & (flag_q | mark);
      end else begin : g_none
         logic unused_inputs;
         assign unused_inputs = &{1'b0, clk, rst_n, clear, mark, close};
         assign bad_now = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/cif_out_stage.sv
module cif_out_stage #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_first,
   input  logic              in_last,
   input  logic              in_bad,
   input  logic              in_drop,
   output logic              o_valid,
   output logic [DATA_W-1:0] o_data,
   output logic              o_first,
   output logic              o_last,
   output logic              o_bad,
   output logic              o_drop
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         o_valid <= 1'b0;
         o_first <= 1'b0;
         o_last  <= 1'b0;
         o_bad   <= 1'b0;
         o_drop  <= 1'b0;
      end else begin
         o_valid <= in_valid;
         o_first <= in_first;
         o_last  <= in_last;
         o_bad   <= in_bad;
         o_drop  <= in_drop;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         o_data <= '0;
      end else if (in_valid) begin
         o_data <= in_data;
      end
   end

endmodule

// File: rtl/cif_framer.sv
module cif_framer #(
   parameter int CELL_BYTES = 53,
   parameter int BEAT_BYTES = 1,
   parameter bit ERR_EN     = 1'b1,
   localparam int DATA_W     = 8 * BEAT_BYTES,
   localparam int CELL_BEATS = CELL_BYTES / BEAT_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_n,
   input  logic              sof,
   input  logic              room,
   input  logic [DATA_W-1:0] din,
   output logic              o_valid,
   output logic [DATA_W-1:0] o_data,
   output logic              o_first,
   output logic              o_last,
   output logic              o_bad,
   output logic              o_drop
);

   import cif_pkg::*;

   generate
      if (BEAT_BYTES < 1) begin : g_chk_beat
         $error("cif_framer: BEAT_BYTES must be at least 1");
      end
      if ((CELL_BYTES % BEAT_BYTES) != 0) begin : g_chk_div
         $error("cif_framer: CELL_BYTES must be a multiple of BEAT_BYTES");
      end
      if (CELL_BEATS < 2) begin : g_chk_len
         $error("cif_framer: a cell needs at least two beats");
      end
   endgenerate

   cif_state_e state_q;
   logic       wr_ok;
   logic       in_fill;
   logic       start;
   logic       take;
   logic       early;
   logic       at_end;
   logic       close;
   logic       drop;
   logic       bad_now;

   assign wr_ok   = ~wr_n;
   assign in_fill = (state_q == CIF_FILL);
   assign start   = ~in_fill & wr_ok & sof & room;
   assign drop    = ~in_fill & wr_ok & ~start;
   assign take    = in_fill & wr_ok;
   assign early   = take & sof;
   assign close   = take & at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CIF_HUNT;
      end else if (start) begin
         state_q <= CIF_FILL;
      end else if (close) begin
         state_q <= CIF_HUNT;
      end
   end

   cif_beat_counter #(
      .CELL_BEATS(CELL_BEATS)
   ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (start),
      .step   (take),
      .at_end (at_end)
   );

   cif_fault_track #(
      .ERR_EN(ERR_EN)
   ) u_fault (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (start),
      .mark    (early),
      .close   (close),
      .bad_now (bad_now)
   );

   cif_out_stage #(
      .DATA_W(DATA_W)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (start | take),
      .in_data  (din),
      .in_first (start),
      .in_last  (close),
      .in_bad   (bad_now),
      .in_drop  (drop),
      .o_valid  (o_valid),
      .o_data   (o_data),
      .o_first  (o_first),
      .o_last   (o_last),
      .o_bad    (o_bad),
      .o_drop   (o_drop)
   );

endmodule

// File: rtl/cif_framer_chk.sv
module cif_framer_chk #(
   parameter int CELL_BEATS = 53,
   localparam int CW = cif_pkg::cif_cnt_width(CELL_BEATS)
) (
   input logic clk,
   input logic rst_n,
   input logic wr_n,
   input logic o_valid,
   input logic o_first,
   input logic o_last,
   input logic o_bad,
   input logic o_drop
);

   logic          c_in;
   logic [CW-1:0] c_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_in  <= 1'b0;
         c_cnt <= '0;
      end else if (o_valid && o_first) begin
         c_in  <= ~o_last;
         c_cnt <= CW'(1);
      end else if (o_valid) begin
         c_cnt <= c_cnt + CW'(1);
         if (o_last) c_in <= 1'b0;
      end
   end

   a_r9_valid_drop_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(o_valid && o_drop));

   a_r3_first_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
      o_first |-> o_valid);

   a_r9_last_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
      o_last |-> o_valid);

   a_r7_bad_on_last: assert property (@(posedge clk) disable iff (!rst_n)
      o_bad |-> o_last);

   a_r8_idle_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      wr_n |=> (!o_valid && !o_drop));

   a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (c_in && o_valid) |-> !o_first);

   a_r6_open_needs_first: assert property (@(posedge clk) disable iff (!rst_n)
      (!c_in && o_valid) |-> o_first);

   a_r4_cell_length: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && o_last && !o_first) |-> (c_cnt == CW'(CELL_BEATS - 1)));

endmodule

bind cif_framer cif_framer_chk #(
   .CELL_BEATS(CELL_BEATS)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_n    (wr_n),
   .o_valid (o_valid),
   .o_first (o_first),
   .o_last  (o_last),
   .o_bad   (o_bad),
   .o_drop  (o_drop)
);

// File: tb/cif_framer_bench.sv
module cif_framer_bench;

   localparam int CLK_PERIOD = 10;
   localparam int CELL = 53;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_n = 1'b1;
   logic       sof = 1'b0;
   logic       room = 1'b0;
   logic [7:0] din = '0;
   logic       o_valid, o_first, o_last, o_bad, o_drop;
   logic [7:0] o_data;

   int n_cmp = 0;
   int n_bad = 0;
   int seen_cells = 0;
   int seen_bad = 0;
   int seen_drop = 0;
   bit done = 1'b0;
   string cur_req = "R1";

   // reference model state
   bit         m_in = 0;
   int         m_cnt = 0;
   bit         m_err = 0;
   bit         e_valid = 0, e_first = 0, e_last = 0, e_bad = 0, e_drop = 0;
   logic [7:0] e_data = '0;
   string      e_req = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   cif_framer u_cif_framer (
      .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .sof(sof), .room(room), .din(din),
      .o_valid(o_valid), .o_data(o_data), .o_first(o_first), .o_last(o_last),
      .o_bad(o_bad), .o_drop(o_drop)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // behavioural reference: expected registered outputs for the coming cycle
   always @(posedge clk) begin
      e_req = cur_req;
      if (!rst_n) begin
         m_in = 0; m_cnt = 0; m_err = 0;
         e_valid = 0; e_first = 0; e_last = 0; e_bad = 0; e_drop = 0;
      end else begin
         e_valid = 0; e_first = 0; e_last = 0; e_bad = 0; e_drop = 0;
         if (!wr_n) begin
            if (!m_in) begin
               if (sof && room) begin
                  m_in = 1; m_cnt = 1; m_err = 0;
                  e_valid = 1; e_first = 1; e_data = din;
               end else begin
                  e_drop = 1;
               end
            end else begin
               e_valid = 1; e_data = din;
               if (sof) m_err = 1;
               m_cnt++;
               if (m_cnt == CELL) begin
                  e_last = 1; e_bad = m_err; m_in = 0;
               end
            end
         end
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         chk(e_req, "o_valid (R3)", o_valid, e_valid);
         chk(e_req, "o_first (R3)", o_first, e_first);
         chk(e_req, "o_last (R4)",  o_last,  e_last);
         chk(e_req, "o_bad (R7)",   o_bad,   e_bad);
         chk(e_req, "o_drop (R6)",  o_drop,  e_drop);
         if (e_valid) chk(e_req, "o_data (R3)", o_data, e_data);
         if (rst_n) begin
            if (o_valid && o_last) seen_cells++;
            if (o_bad) seen_bad++;
            if (o_drop) seen_drop++;
         end
      end
   end

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         wr_n = 1'b1; sof = 1'b0;
      end
   endtask

   task automatic send(input int n, input logic [7:0] base, input bit first_sof,
                       input bit room_v, input int gap_every);
      for (int i = 0; i < n; i++) begin
         if (gap_every > 0 && (i % gap_every) == gap_every - 1) begin
            @(negedge clk);
            wr_n = 1'b1; sof = 1'b1; room = 1'b1; din = 8'hEE;
         end
         @(negedge clk);
         wr_n = 1'b0;
         sof  = first_sof && (i == 0);
         room = room_v;
         din  = base + 8'(i);
      end
   endtask

   initial begin
      cur_req = "R1";
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(2);

      cur_req = "R3";                     // plain cell
      send(CELL, 8'h10, 1, 1, 0);
      idle(3);

      cur_req = "R8";                     // bubbles with sof set while wr_n high
      send(CELL, 8'h40, 1, 1, 4);
      idle(3);

      cur_req = "R2";                     // start offered without room: all dropped
      send(CELL, 8'h80, 1, 0, 0);
      idle(2);
      @(negedge clk); wr_n = 1'b1; sof = 1'b1; room = 1'b1;
      send(CELL, 8'h90, 1, 1, 0);
      idle(3);

      cur_req = "R6";                     // long cell, five beats too many
      send(CELL + 5, 8'h20, 1, 1, 0);
      idle(3);

      cur_req = "R5";                     // short cell of 20 then a full cell
      send(20, 8'hA0, 1, 1, 0);
      send(CELL, 8'h00, 1, 1, 0);
      cur_req = "R7";                     // third cell frames cleanly
      send(CELL, 8'hC0, 1, 1, 0);
      idle(3);

      cur_req = "R6";                     // stray beats, then back-to-back cells
      send(7, 8'h70, 0, 1, 0);
      cur_req = "R4";
      send(CELL, 8'h30, 1, 1, 0);
      send(CELL, 8'h50, 1, 1, 0);
      idle(4);

      done = 1'b1;
      chk("R4", "completed cells", seen_cells, 8);
      chk("R7", "cells flagged bad", seen_bad, 1);
      chk("R6", "dropped beats", seen_drop, 53 + 5 + 20 + 7);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule